// File: doc/BRIEF.md
# Shared Interrupt Source Conditioner

This block takes a parameterised number of shared interrupt lines, up to 256, and turns each raw wire into a clean pending bit. Each source can be set to level or edge sensing. In level mode the source can be active high or active low. In edge mode it can latch on the rising edge, on the falling edge, or on both edges. Software can also inject or retire an edge event on any source by writing one command word. A per-source mask bit has separate write-one-to-set and write-one-to-clear locations. Each pending source that is unmasked is then steered by its own routing word. The routing word can send the source to one of up to 64 request pins, to the non-maskable request line, or to both.

Raw inputs pass through a two-flop synchroniser. Edge detection compares the synchronised sample with the sample taken one cycle earlier. An edge therefore reaches the pending bit three clocks after the input changes, while level sensing takes two clocks. Configuration goes over a plain 32-bit register bus with a combinational read port. The bit arrays are packed 32 sources per word, and source i sits in bit i%32 of word i/32.

Top module: `irq_src_shaper`

## Requirements
- R1: After reset, every mask bit, every polarity, trigger and dual bit, every edge latch and every routing word is zero, so `pend_masked`, `pin_req` and `nmi_req` are all zero.
- R2: A trigger bit of 0 selects level sensing. The pending bit equals the input two clocks earlier when polarity is 1, and its inverse when polarity is 0.
- R3: A trigger bit of 1 selects edge sensing. With the dual bit at 0, polarity 1 latches a rising edge and polarity 0 latches a falling edge, three clocks after the input change. The latched bit stays set until software retires it.
- R4: In edge mode with the dual bit at 1, both edges latch and polarity has no effect.
- R5: A write to 0x280 selects a source with bits 7:0 and sets (bit 31 = 1) or clears (bit 31 = 0) that source's edge latch. A source number of N or more is ignored. If a hardware edge arrives in the same cycle as a clear, the latch ends up set. The word reads as zero.
- R6: Writing 1s to the word at 0x300 + 4w clears the matching mask bits, and writing 1s to 0x380 + 4w sets them. Zero bits leave the mask unchanged. The mask reads back at 0x400 + 4w, and both command words read as zero.
- R7: Pending bits read back at 0x480 + 4w. The output `pend_masked` equals pending AND mask. Writes to the mask and pending readback words have no effect.
- R8: The routing word of source i is at 0x500 + 4i. Bit 31 enables pin routing, bit 30 enables non-maskable routing, and bits 5:0 hold the pin number. All other bits read as zero.
- R9: `pin_req[p]` is high exactly when some source is pending, unmasked, has routing bit 31 set and has pin field p. A pin field of NUM_PINS or more drives no pin.
- R10: `nmi_req` is high exactly when some source is pending, unmasked and has routing bit 30 set.
- R11: Polarity, trigger and dual words are read/write at 0x100 + 4w, 0x180 + 4w and 0x200 + 4w. Unaligned or unmapped addresses read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | NUM_SRC | Raw shared interrupt lines |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wen | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| pend_masked | output | NUM_SRC | Pending AND mask, per source |
| pin_req | output | NUM_PINS | Per-pin request lines |
| nmi_req | output | 1 | Non-maskable request line |

## Verification
The assertions check four things on every cycle. Each mask command must land on the next cycle, and the mask must hold when no command is written. A latched edge may fall only when software retires it, and a software edge command touches at most one source. No pin or non-maskable request may appear without a masked pending source. Other behaviour can only be shown by the bench's scenarios. These include the sync latency, which edge polarity latches, dual-edge sensing, the tie between a hardware edge and a software clear, the rejection of out-of-range source numbers and pin fields, and the address decode.

// File: rtl/irq_shaper_pkg.sv
package irq_shaper_pkg;

  localparam int WORD_BITS   = 32;
  localparam int ARRAY_BYTES = 'h80;
  localparam int OFS_POL     = 'h100;
  localparam int OFS_TRIG    = 'h180;
  localparam int OFS_DUAL    = 'h200;
  localparam int OFS_SWEDGE  = 'h280;
  localparam int OFS_MCLR    = 'h300;
  localparam int OFS_MSET    = 'h380;
  localparam int OFS_MASK    = 'h400;
  localparam int OFS_PEND    = 'h480;
  localparam int OFS_MAP     = 'h500;

  typedef struct packed {
    logic       to_pin;
    logic       to_nmi;
    logic [5:0] pin;
  } route_t;

  function automatic route_t route_from_word(logic [31:0] w);
    route_t r;
    r.to_pin = w[31];
    r.to_nmi = w[30];
    r.pin    = w[5:0];
    return r;
  endfunction

  function automatic logic [31:0] route_to_word(route_t r);
    return {r.to_pin, r.to_nmi, 24'b0, r.pin};
  endfunction

  // edge event on the synchronised sample: cur is newest, old is one cycle before
  function automatic logic edge_seen(logic trig, logic dual, logic pol, logic cur, logic old);
    logic rise, fall;
    rise = cur & ~old;
    fall = ~cur & old;
    if (!trig) return 1'b0;
    if (dual)  return rise | fall;
    return pol ? rise : fall;
  endfunction

  function automatic logic level_on(logic pol, logic cur);
    return pol ? cur : ~cur;
  endfunction

endpackage

// File: rtl/irq_src_lane.sv
module irq_src_lane
  import irq_shaper_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  input  logic pol,
  input  logic trig,
  input  logic dual,
  input  logic sw_set,
  input  logic sw_clr,
  output logic pend,
  output logic latched,
  output logic hw_edge
);

  logic sync1, sync2, prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1   <= 1'b0;
      sync2   <= 1'b0;
      prev    <= 1'b0;
      latched <= 1'b0;
    end else begin
      sync1   <= raw;
      sync2   <= sync1;
      prev    <= sync2;
      latched <= (latched & ~sw_clr) | sw_set | hw_edge;
    end
  end

  assign hw_edge = edge_seen(trig, dual, pol, sync2, prev);
  assign pend    = trig ? latched : level_on(pol, sync2);

endmodule

// File: rtl/irq_src_regs.sv
module irq_src_regs
  import irq_shaper_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wen,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [NUM_SRC-1:0]   pend_in,
  output logic [NUM_SRC-1:0]   pol_q,
  output logic [NUM_SRC-1:0]   trig_q,
  output logic [NUM_SRC-1:0]   dual_q,
  output logic [NUM_SRC-1:0]   mask_q,
  output route_t [NUM_SRC-1:0] route_q,
  output logic [NUM_SRC-1:0]   sw_set,
  output logic [NUM_SRC-1:0]   sw_clr,
  output logic [NUM_SRC-1:0]   mset_bits,
  output logic [NUM_SRC-1:0]   mclr_bits,
  output logic                 wr_mset,
  output logic                 wr_mclr
);

  localparam int IDX_W = 5;
  localparam logic [31:0] RG_POL  = 32'(OFS_POL  / ARRAY_BYTES);
  localparam logic [31:0] RG_TRIG = 32'(OFS_TRIG / ARRAY_BYTES);
  localparam logic [31:0] RG_DUAL = 32'(OFS_DUAL / ARRAY_BYTES);
  localparam logic [31:0] RG_MCLR = 32'(OFS_MCLR / ARRAY_BYTES);
  localparam logic [31:0] RG_MSET = 32'(OFS_MSET / ARRAY_BYTES);
  localparam logic [31:0] RG_MASK = 32'(OFS_MASK / ARRAY_BYTES);
  localparam logic [31:0] RG_PEND = 32'(OFS_PEND / ARRAY_BYTES);
  localparam logic [31:0] MAP_END = 32'(OFS_MAP + 4 * NUM_SRC);

  // place a bus word onto the source vector at word index k
  function automatic logic [NUM_SRC-1:0] spread(logic [31:0] w, logic [IDX_W-1:0] k);
    logic [NUM_SRC-1:0] v;
    for (int i = 0; i < NUM_SRC; i++)
      v[i] = (i / WORD_BITS == int'(k)) ? w[i % WORD_BITS] : 1'b0;
    return v;
  endfunction

  // pull word index k out of a source vector
  function automatic logic [31:0] gather(logic [NUM_SRC-1:0] v, logic [IDX_W-1:0] k);
    logic [31:0] w;
    w = '0;
    for (int b = 0; b < WORD_BITS; b++)
      if (int'(k) * WORD_BITS + b < NUM_SRC) w[b] = v[int'(k) * WORD_BITS + b];
    return w;
  endfunction

  logic [31:0]        a_ext, region, map_idx;
  logic [IDX_W-1:0]   widx;
  logic               aligned, map_sel, wr_pol, wr_trig, wr_dual, wr_map, sw_ok;
  logic [NUM_SRC-1:0] word_lanes, wr_word, src_onehot;

  assign a_ext   = 32'(bus_addr);
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign widx    = bus_addr[6:2];
  assign region  = a_ext >> 7;
  assign map_sel = aligned && (a_ext >= 32'(OFS_MAP)) && (a_ext < MAP_END);
  assign map_idx = (a_ext - 32'(OFS_MAP)) >> 2;

  assign wr_pol  = bus_wen && aligned && (region == RG_POL);
  assign wr_trig = bus_wen && aligned && (region == RG_TRIG);
  assign wr_dual = bus_wen && aligned && (region == RG_DUAL);
  assign wr_mclr = bus_wen && aligned && (region == RG_MCLR);
  assign wr_mset = bus_wen && aligned && (region == RG_MSET);
  assign wr_map  = bus_wen && map_sel;

  assign word_lanes = spread('1, widx);
  assign wr_word    = spread(bus_wdata, widx);
  assign mset_bits  = wr_mset ? wr_word : '0;
  assign mclr_bits  = wr_mclr ? wr_word : '0;

  assign sw_ok = bus_wen && aligned && (a_ext == 32'(OFS_SWEDGE)) &&
                 (32'(bus_wdata[7:0]) < 32'(NUM_SRC));

  always_comb begin
    for (int i = 0; i < NUM_SRC; i++)
      src_onehot[i] = (32'(bus_wdata[7:0]) == 32'(i));
  end

  assign sw_set = (sw_ok &&  bus_wdata[31]) ? src_onehot : '0;
  assign sw_clr = (sw_ok && !bus_wdata[31]) ? src_onehot : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q   <= '0;
      trig_q  <= '0;
      dual_q  <= '0;
      mask_q  <= '0;
      route_q <= '0;
    end else begin
      if (wr_pol)  pol_q  <= (pol_q  & ~word_lanes) | wr_word;
      if (wr_trig) trig_q <= (trig_q & ~word_lanes) | wr_word;
      if (wr_dual) dual_q <= (dual_q & ~word_lanes) | wr_word;
      mask_q <= (mask_q & ~mclr_bits) | mset_bits;
      for (int i = 0; i < NUM_SRC; i++)
        if (wr_map && (map_idx == 32'(i))) route_q[i] <= route_from_word(bus_wdata);
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (map_sel) begin
      for (int i = 0; i < NUM_SRC; i++)
        if (map_idx == 32'(i)) bus_rdata = route_to_word(route_q[i]);
    end else if (aligned) begin
      if (region == RG_POL)       bus_rdata = gather(pol_q, widx);
      else if (region == RG_TRIG) bus_rdata = gather(trig_q, widx);
      else if (region == RG_DUAL) bus_rdata = gather(dual_q, widx);
      else if (region == RG_MASK) bus_rdata = gather(mask_q, widx);
      else if (region == RG_PEND) bus_rdata = gather(pend_in, widx);
    end
  end

endmodule

// File: rtl/irq_src_router.sv
module irq_src_router
  import irq_shaper_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int NUM_PINS = 8
) (
  input  logic [NUM_SRC-1:0]   pend_m,
  input  route_t [NUM_SRC-1:0] route_q,
  output logic [NUM_PINS-1:0]  pin_req,
  output logic                 nmi_req
);

  function automatic logic pin_hit(logic [NUM_SRC-1:0] pm, route_t [NUM_SRC-1:0] rt, int p);
    logic hit;
    hit = 1'b0;
    for (int i = 0; i < NUM_SRC; i++)
      if (pm[i] && rt[i].to_pin && (rt[i].pin == 6'(p))) hit = 1'b1;
    return hit;
  endfunction

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    assign pin_req[p] = pin_hit(pend_m, route_q, p);
  end

  always_comb begin
    nmi_req = 1'b0;
    for (int i = 0; i < NUM_SRC; i++)
      if (pend_m[i] && route_q[i].to_nmi) nmi_req = 1'b1;
  end

endmodule

// File: rtl/irq_src_shaper.sv
module irq_src_shaper
  import irq_shaper_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int NUM_PINS = 8,
  parameter int ADDR_W   = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_SRC-1:0]  src_in,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wen,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic [NUM_SRC-1:0]  pend_masked,
  output logic [NUM_PINS-1:0] pin_req,
  output logic                nmi_req
);

  logic [NUM_SRC-1:0]   pol_q, trig_q, dual_q, mask_q;
  logic [NUM_SRC-1:0]   sw_set, sw_clr, mset_bits, mclr_bits;
  logic [NUM_SRC-1:0]   pend_all, edge_q, hw_edge;
  logic                 wr_mset, wr_mclr;
  route_t [NUM_SRC-1:0] route_q;

  irq_src_regs #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wen   (bus_wen),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pend_in   (pend_all),
    .pol_q     (pol_q),
    .trig_q    (trig_q),
    .dual_q    (dual_q),
    .mask_q    (mask_q),
    .route_q   (route_q),
    .sw_set    (sw_set),
    .sw_clr    (sw_clr),
    .mset_bits (mset_bits),
    .mclr_bits (mclr_bits),
    .wr_mset   (wr_mset),
    .wr_mclr   (wr_mclr)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_lane
    irq_src_lane u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .raw     (src_in[i]),
      .pol     (pol_q[i]),
      .trig    (trig_q[i]),
      .dual    (dual_q[i]),
      .sw_set  (sw_set[i]),
      .sw_clr  (sw_clr[i]),
      .pend    (pend_all[i]),
      .latched (edge_q[i]),
      .hw_edge (hw_edge[i])
    );
  end

  assign pend_masked = pend_all & mask_q;

  irq_src_router #(.NUM_SRC(NUM_SRC), .NUM_PINS(NUM_PINS)) u_router (
    .pend_m  (pend_masked),
    .route_q (route_q),
    .pin_req (pin_req),
    .nmi_req (nmi_req)
  );

endmodule

// File: rtl/irq_src_shaper_chk.sv
module irq_src_shaper_chk #(
  parameter int NUM_SRC  = 32,
  parameter int NUM_PINS = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_SRC-1:0]  mask_q,
  input logic [NUM_SRC-1:0]  edge_q,
  input logic [NUM_SRC-1:0]  sw_set,
  input logic [NUM_SRC-1:0]  sw_clr,
  input logic [NUM_SRC-1:0]  mset_bits,
  input logic [NUM_SRC-1:0]  mclr_bits,
  input logic                wr_mset,
  input logic                wr_mclr,
  input logic [NUM_SRC-1:0]  pend_masked,
  input logic [NUM_PINS-1:0] pin_req,
  input logic                nmi_req
);

  a_r6_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mset |=> ((mask_q & $past(mset_bits)) == $past(mset_bits)));

  a_r6_clear_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mclr |=> ((mask_q & $past(mclr_bits)) == '0));

  a_r6_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_mset && !wr_mclr) |=> $stable(mask_q));

  a_r3_edge_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (|edge_q) |=> (($past(edge_q) & ~$past(sw_clr) & ~edge_q) == '0));

  a_r5_single_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sw_set | sw_clr));

  a_r5_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (|sw_set) |=> ((edge_q & $past(sw_set)) == $past(sw_set)));

  a_r7_masked_only: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_masked & ~mask_q) == '0));

  a_r9_pin_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    (|pin_req) |-> (|pend_masked));

  a_r10_nmi_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |-> (|pend_masked));

endmodule

bind irq_src_shaper irq_src_shaper_chk #(.NUM_SRC(NUM_SRC), .NUM_PINS(NUM_PINS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mask_q      (mask_q),
  .edge_q      (edge_q),
  .sw_set      (sw_set),
  .sw_clr      (sw_clr),
  .mset_bits   (mset_bits),
  .mclr_bits   (mclr_bits),
  .wr_mset     (wr_mset),
  .wr_mclr     (wr_mclr),
  .pend_masked (pend_masked),
  .pin_req     (pin_req),
  .nmi_req     (nmi_req)
);

// File: tb/irq_src_shaper_test.sv
module irq_src_shaper_test;

  localparam int CLK_PERIOD = 10;
  localparam int NS = 40;
  localparam int NP = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NS-1:0] src_in;
  logic [11:0]   bus_addr;
  logic          bus_wen;
  logic [31:0]   bus_wdata;
  logic [31:0]   bus_rdata;
  logic [NS-1:0] pend_masked;
  logic [NP-1:0] pin_req;
  logic          nmi_req;

  always #(CLK_PERIOD / 2) clk = ~clk;

  irq_src_shaper #(.NUM_SRC(NS), .NUM_PINS(NP), .ADDR_W(12)) uut (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_addr(bus_addr),
    .bus_wen(bus_wen), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pend_masked(pend_masked), .pin_req(pin_req), .nmi_req(nmi_req)
  );

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  // behavioural reference: history of the input and per-source settings
  bit          h1[NS], h2[NS], h3[NS];
  bit          m_lat[NS], m_pol[NS], m_trig[NS], m_dual[NS], m_mask[NS];
  logic [31:0] m_map[NS];

  function automatic bit m_pend(int i);
    if (m_trig[i]) return m_lat[i];
    return m_pol[i] ? h2[i] : !h2[i];
  endfunction

  function automatic logic [31:0] m_read(int a);
    logic [31:0] r;
    r = 0;
    if (a % 4 != 0) return 0;
    if (a >= 'h500 && a < 'h500 + 4 * NS) return m_map[(a - 'h500) / 4];
    for (int b = 0; b < 32; b++) begin
      int k;
      k = ((a % 'h80) / 4) * 32 + b;
      if (k < NS) begin
        case (a / 'h80)
          2: r[b] = m_pol[k];
          3: r[b] = m_trig[k];
          4: r[b] = m_dual[k];
          8: r[b] = m_mask[k];
          9: r[b] = m_pend(k);
          default: ;
        endcase
      end
    end
    return r;
  endfunction

  function automatic string rtag(int a);
    if (a >= 'h500) return "R8";
    case (a / 'h80)
      2, 3, 4: return "R11";
      6, 7, 8: return "R6";
      9:       return "R7";
      default: return "R5";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NS; i++) begin
        h1[i] = 0; h2[i] = 0; h3[i] = 0; m_lat[i] = 0; m_pol[i] = 0;
        m_trig[i] = 0; m_dual[i] = 0; m_mask[i] = 0; m_map[i] = 0;
      end
    end else begin
      int a;
      a = int'(bus_addr);
      for (int i = 0; i < NS; i++) begin
        bit rise, fall, ev, nl;
        rise = h2[i] && !h3[i];
        fall = !h2[i] && h3[i];
        ev = m_trig[i] && (m_dual[i] ? (rise || fall) : (m_pol[i] ? rise : fall));
        nl = m_lat[i];
        if (bus_wen && a == 'h280 && int'(bus_wdata[7:0]) == i) nl = bus_wdata[31];
        if (ev) nl = 1;
        m_lat[i] = nl;
        h3[i] = h2[i]; h2[i] = h1[i]; h1[i] = src_in[i];
      end
      if (bus_wen && a % 4 == 0) begin
        if (a >= 'h500 && a < 'h500 + 4 * NS)
          m_map[(a - 'h500) / 4] = bus_wdata & 32'hC000_003F;
        else
          for (int b = 0; b < 32; b++) begin
            int k;
            k = ((a % 'h80) / 4) * 32 + b;
            if (k < NS) begin
              case (a / 'h80)
                2: m_pol[k]  = bus_wdata[b];
                3: m_trig[k] = bus_wdata[b];
                4: m_dual[k] = bus_wdata[b];
                6: if (bus_wdata[b]) m_mask[k] = 0;
                7: if (bus_wdata[b]) m_mask[k] = 1;
                default: ;
              endcase
            end
          end
      end
    end
  end

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) begin
      logic [NS-1:0] epm;
      logic [NP-1:0] epin;
      logic          enmi;
      epin = '0;
      enmi = 0;
      for (int i = 0; i < NS; i++) begin
        epm[i] = m_pend(i) && m_mask[i];
        if (epm[i] && m_map[i][30]) enmi = 1;
        for (int p = 0; p < NP; p++)
          if (epm[i] && m_map[i][31] && int'(m_map[i][5:0]) == p) epin[p] = 1;
      end
      check("R7 pend_masked", 64'(pend_masked), 64'(epm));
      check("R9 pin_req", 64'(pin_req), 64'(epin));
      check("R10 nmi_req", 64'(nmi_req), 64'(enmi));
      check({rtag(int'(bus_addr)), " rdata"}, 64'(bus_rdata), 64'(m_read(int'(bus_addr))));
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(int a, logic [31:0] d);
    bus_addr = a[11:0]; bus_wdata = d; bus_wen = 1;
    tick(1);
    bus_wen = 0;
  endtask

  task automatic rd(int a, logic [31:0] exp, string tag);
    bus_addr = a[11:0];
    #1;
    check(tag, 64'(bus_rdata), 64'(exp));
  endtask

  task automatic summary();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: run did not finish, actual hang expected completion");
    summary();
  end

  initial begin
    logic [31:0] lfsr;
    rst_n = 0; src_in = '0; bus_addr = '0; bus_wen = 0; bus_wdata = '0;
    tick(2);
    rst_n = 1;
    tick(1);
    // R1 reset state; active-low level sources with low inputs are pending but masked
    rd('h400, 32'h0, "R1 mask after reset");
    rd('h480, 32'hFFFF_FFFF, "R1 pending w0 after reset");
    rd('h484, 32'h0000_00FF, "R1 pending w1 after reset");
    rd('h50C, 32'h0, "R1 map after reset");
    check("R1 pend_masked", 64'(pend_masked), 64'h0);
    check("R1 pin_req/nmi", 64'({pin_req, nmi_req}), 64'h0);

    // R2 level sensing with two-clock latency
    wr('h100, 32'hFFFF_FFFF);
    rd('h480, 32'h0, "R2 active-high idle");
    src_in[3] = 1;
    tick(1);
    rd('h480, 32'h0, "R2 not yet through sync");
    tick(1);
    rd('h480, 32'h8, "R2 level pending");

    // R3 single edge: src4 rising, src6 falling-sensitive
    wr('h180, 32'h0000_00F0);
    wr('h100, 32'hFFFF_FF3F);
    rd('h480, 32'h8, "R3 no edge yet");
    src_in[4] = 1; src_in[6] = 1;
    tick(3);
    rd('h480, 32'h18, "R3 rising latched, falling-sensitive idle");
    src_in[4] = 0; src_in[6] = 0;
    tick(3);
    rd('h480, 32'h58, "R3 sticky and falling latched");

    // R4 dual edge on src5
    wr('h200, 32'h0000_0020);
    src_in[5] = 1;
    tick(3);
    rd('h480, 32'h78, "R4 dual rise");
    wr('h280, 32'h0000_0005);
    rd('h480, 32'h58, "R5 software clear");
    src_in[5] = 0;
    tick(3);
    rd('h480, 32'h78, "R4 dual fall");

    // R5 software set, out-of-range number, edge wins over clear
    wr('h280, 32'h8000_0007);
    rd('h480, 32'hF8, "R5 software set");
    wr('h280, 32'h8000_002D);
    rd('h484, 32'h0000_00FF, "R5 out-of-range ignored");
    rd('h480, 32'hF8, "R5 out-of-range ignored w0");
    rd('h280, 32'h0, "R5 command reads zero");
    wr('h280, 32'h0000_0004);
    rd('h480, 32'hE8, "R5 clear src4");
    src_in[4] = 1;
    tick(2);
    wr('h280, 32'h0000_0004);
    rd('h480, 32'hF8, "R5 hardware edge wins tie");

    // R6 mask set and clear
    wr('h380, 32'h0000_00F8);
    wr('h300, 32'h0000_0010);
    rd('h400, 32'hE8, "R6 mask after set/clear");
    wr('h300, 32'h0);
    rd('h400, 32'hE8, "R6 zero bits no effect");
    rd('h380, 32'h0, "R6 set word reads zero");
    wr('h400, 32'h0);
    rd('h400, 32'hE8, "R7 mask readback not writable");
    wr('h480, 32'hFFFF_FFFF);
    rd('h480, 32'hF8, "R7 pending readback not writable");
    check("R7 pend_masked value", 64'(pend_masked), 64'hE8);

    // R8 routing words, R9 pins, R10 nmi
    wr('h50C, 32'hFFFF_FFC2);
    rd('h50C, 32'hC000_0002, "R8 unused bits read zero");
    check("R9 src3 to pin2", 64'(pin_req), 64'b000100);
    check("R10 src3 nmi", 64'(nmi_req), 64'h1);
    wr('h51C, 32'h8000_0005);
    check("R9 src7 to pin5", 64'(pin_req), 64'b100100);
    wr('h518, 32'h8000_0028);
    check("R9 pin field out of range", 64'(pin_req), 64'b100100);
    wr('h300, 32'h0000_0008);
    check("R9 masked src3 drops pin", 64'(pin_req), 64'b100000);
    check("R10 masked src3 drops nmi", 64'(nmi_req), 64'h0);

    // R11 configuration readback and unaligned access
    rd('h100, 32'hFFFF_FF3F, "R11 polarity w0");
    rd('h180, 32'h0000_00F0, "R11 trigger w0");
    rd('h200, 32'h0000_0020, "R11 dual w0");
    rd('h104, 32'h0, "R11 polarity w1");
    wr('h102, 32'h0);
    rd('h100, 32'hFFFF_FF3F, "R11 unaligned write ignored");
    rd('h102, 32'h0, "R11 unaligned read zero");

    // mixed traffic checked by the reference every cycle
    lfsr = 32'hACE1_1234;
    for (int c = 0; c < 3000; c++) begin
      int a;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      src_in = {lfsr[7:0], lfsr} ^ {src_in[38:0], src_in[39]};
      case (lfsr[11:8])
        0: a = 'h100;  1: a = 'h104;  2: a = 'h180;  3: a = 'h184;
        4: a = 'h200;  5: a = 'h280;  6: a = 'h300;  7: a = 'h304;
        8: a = 'h380;  9: a = 'h384; 10: a = 'h400; 11: a = 'h480;
        12: a = 'h484; 13: a = 'h103; default: a = 'h500 + 4 * int'(lfsr[17:12] % 42);
      endcase
      bus_addr = a[11:0];
      bus_wdata = (a == 'h280) ? {lfsr[31], 25'b0, lfsr[5:0]} : {lfsr[15:0], lfsr[31:16]} ^ lfsr;
      bus_wen = (lfsr[20:19] == 2'b00);
      tick(1);
      bus_wen = 0;
    end
    tick(2);
    summary();
  end

endmodule